// File: doc/BRIEF.md
# Scatter-Gather Page Address Translator

This block converts a transfer described by a linear byte offset and a byte length into a series of physical-memory requests. The linear space is divided into fixed-size pages. The physical base of each page comes from a descriptor table in memory. For every page the transfer touches, the block reads that page's descriptor and adds the offset within the page. It then issues one request that carries the physical address, the byte count and the direction. It waits for that request to complete before it moves on.

A client loads the table base, the highest legal table index, the start offset, the length and the direction, then pulses `start`. The first request covers only the part of the first page from the start offset onward. Every request after it begins at offset zero of the next page and covers a whole page or the bytes still left, whichever is less. The walk aborts with a sticky error if it needs a table entry beyond the configured highest index. It also aborts if a request would reach past the end of physical memory. The data movement itself belongs to the memory side.

Top module: `sg_page_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `descRdValid` and `segValid` are all low.
- R2: The table index of the first page is `linOffset / PAGE_BYTES`. Descriptors sit 8 bytes apart, so entry i is read at `tableBase + 8*i`. Only the 32-bit word at that address is read, once for each segment; the second word of each entry is never read.
- R3: The first segment's physical address is the descriptor word plus `linOffset % PAGE_BYTES`. Its length is the smaller of `PAGE_BYTES - (linOffset % PAGE_BYTES)` and `byteLen`.
- R4: Each later segment uses the next table index and the descriptor word as its address (in-page offset zero). Its length is the smaller of `PAGE_BYTES` and the bytes still to move.
- R5: `segWrite` carries the `dirWrite` value captured at start (1 = write to memory, 0 = read) on every segment of that transfer.
- R6: At most one segment is outstanding. No descriptor read is requested between a segment's acceptance and its `segDone`. A pending `descRdValid` or `segValid` stays high with a stable address until it is accepted.
- R7: A table index greater than `maxIndex` aborts the walk with `error` before that descriptor is requested. An index equal to `maxIndex` is legal.
- R8: A segment whose physical address plus length exceeds `MEM_BYTES` aborts the walk with `error`, and that segment is never issued. Ending exactly at `MEM_BYTES` is legal.
- R9: `done` is a one-cycle pulse at the end of every walk, whether it completes or aborts. `error` holds its value until the next accepted start, which clears it.
- R10: A zero `byteLen` finishes with `done` and no descriptor read or segment.
- R11: A `start` pulse while `busy` is high is ignored, and the running walk proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk with the operands below (when idle) |
| tableBase | input | ADDR_W | Byte address of descriptor table entry 0 |
| maxIndex | input | IDX_W | Highest legal table index |
| linOffset | input | ADDR_W | Linear byte offset of the transfer |
| byteLen | input | LEN_W | Transfer length in bytes |
| dirWrite | input | 1 | 1 = write to memory, 0 = read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | Last walk aborted on a bounds violation |
| descRdValid | output | 1 | Descriptor word read requested |
| descRdReady | input | 1 | Read accepted; descRdData valid this cycle |
| descRdAddr | output | ADDR_W | Descriptor word address |
| descRdData | input | ADDR_W | Physical page base returned |
| segValid | output | 1 | Segment request valid |
| segReady | input | 1 | Segment request accepted |
| segAddr | output | ADDR_W | Segment physical byte address |
| segLen | output | LEN_W | Segment byte count |
| segWrite | output | 1 | Segment direction |
| segDone | input | 1 | Outstanding segment completed |

## Verification
The case to cover is a new `start` arriving in the same cycle that `segDone` completes a segment. The walk is advancing its index and offset in that cycle, and a wrongly accepted start would reload the operands at the same moment. The bench raises `start` with different operands on the edge of `segDone` itself. It then compares every descriptor address and segment against a model of the original transfer. A second coincidence is also tested: a segment completes and leaves the next index one past the limit. Here the bench expects the error, with no further descriptor read.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands
    logic takeDesc;  // capture descriptor word into the physical address
    logic advance;   // segment finished: step to the next page
  } walkCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lenZero;   // nothing left to move
    logic idxOver;   // current index beyond the limit
    logic memOver;   // pending segment runs past physical memory
  } walkStat_t;

endpackage

// File: rtl/sg_walk_dp.sv
module sg_walk_dp
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 32,
  parameter int IDX_W = 16,
  parameter int PAGE_BYTES = 4096,
  parameter longint unsigned MEM_BYTES = 64'd1048576
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [IDX_W-1:0]  maxIndex,
  input  logic [ADDR_W-1:0] linOffset,
  input  logic [LEN_W-1:0]  byteLen,
  input  logic              dirWrite,
  input  logic [ADDR_W-1:0] descRdData,
  output walkStat_t         stat,
  output logic [ADDR_W-1:0] descRdAddr,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              segWrite
);

  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int PI_W = ADDR_W - PG_W;
  localparam int EXT_W = ADDR_W + 2;
  localparam logic [EXT_W-1:0] MEM_LIM = EXT_W'(MEM_BYTES);
  localparam int DESC_SHIFT = 3;  // 8-byte entries

  logic [ADDR_W-1:0] baseReg;
  logic [IDX_W-1:0]  maxReg;
  logic [PI_W-1:0]   pageIdx;
  logic [PG_W-1:0]   inPage;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] physAddr;
  logic              dirReg;

  logic [LEN_W-1:0]  pageRoom;
  logic [LEN_W-1:0]  segLenC;
  logic [EXT_W-1:0]  memEnd;

  always_comb begin
    pageRoom = LEN_W'(PAGE_BYTES) - LEN_W'(inPage);
    segLenC  = (remain < pageRoom) ? remain : pageRoom;
    memEnd   = EXT_W'(physAddr) + EXT_W'(segLenC);
  end

  assign stat.lenZero = (remain == '0);
  assign stat.idxOver = ADDR_W'(pageIdx) > ADDR_W'(maxReg);
  assign stat.memOver = memEnd > MEM_LIM;

  assign descRdAddr = baseReg + (ADDR_W'(pageIdx) << DESC_SHIFT);
  assign segAddr    = physAddr;
  assign segLen     = segLenC;
  assign segWrite   = dirReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      maxReg   <= '0;
      pageIdx  <= '0;
      inPage   <= '0;
      remain   <= '0;
      physAddr <= '0;
      dirReg   <= 1'b0;
    end else begin
      if (cmd.load) begin
        baseReg <= tableBase;
        maxReg  <= maxIndex;
        pageIdx <= linOffset[ADDR_W-1:PG_W];
        inPage  <= linOffset[PG_W-1:0];
        remain  <= byteLen;
        dirReg  <= dirWrite;
      end
      if (cmd.takeDesc) begin
        physAddr <= descRdData + ADDR_W'(inPage);
      end
      if (cmd.advance) begin
        remain  <= remain - segLenC;
        pageIdx <= pageIdx + 1'b1;
        inPage  <= '0;
      end
    end
  end

  // after any segment the walk continues page-aligned
  assert_aligned_after_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> (inPage == '0));

endmodule

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  walkStat_t stat,
  input  logic      descRdReady,
  input  logic      segReady,
  input  logic      segDone,
  output walkCmd_t  cmd,
  output logic      descRdValid,
  output logic      segValid,
  output logic      busy,
  output logic      done,
  output logic      error
);

  walkState_e state;
  logic       doneReg;
  logic       errorFlag;

  always_comb begin
    descRdValid  = (state == ST_FETCH) && !stat.lenZero && !stat.idxOver;
    segValid     = (state == ST_ISSUE) && !stat.memOver;
    cmd.load     = (state == ST_IDLE) && start;
    cmd.takeDesc = descRdValid && descRdReady;
    cmd.advance  = (state == ST_WAIT) && segDone;
  end

  assign busy  = (state != ST_IDLE) || doneReg;
  assign done  = doneReg;
  assign error = errorFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneReg   <= 1'b0;
      errorFlag <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && !doneReg) begin
            errorFlag <= 1'b0;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (stat.lenZero) begin
            doneReg <= 1'b1;
            state   <= ST_IDLE;
          end else if (stat.idxOver) begin
            errorFlag <= 1'b1;
            doneReg   <= 1'b1;
            state     <= ST_IDLE;
          end else if (descRdReady) begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (stat.memOver) begin
            errorFlag <= 1'b1;
            doneReg   <= 1'b1;
            state     <= ST_IDLE;
          end else if (segReady) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (segDone) state <= ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_seg_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (segValid && !segReady) |=> segValid);

  assert_desc_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (descRdValid && !descRdReady) |=> descRdValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !start) |=> $stable(errorFlag));

endmodule

// File: rtl/sg_page_walker.sv
module sg_page_walker
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 32,
  parameter int IDX_W = 16,
  parameter int PAGE_BYTES = 4096,
  parameter longint unsigned MEM_BYTES = 64'd1048576
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [IDX_W-1:0]  maxIndex,
  input  logic [ADDR_W-1:0] linOffset,
  input  logic [LEN_W-1:0]  byteLen,
  input  logic              dirWrite,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              descRdValid,
  input  logic              descRdReady,
  output logic [ADDR_W-1:0] descRdAddr,
  input  logic [ADDR_W-1:0] descRdData,
  output logic              segValid,
  input  logic              segReady,
  output logic [ADDR_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              segWrite,
  input  logic              segDone
);

  walkCmd_t  cmd;
  walkStat_t stat;

  sg_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .descRdReady(descRdReady), .segReady(segReady), .segDone(segDone),
    .cmd(cmd), .descRdValid(descRdValid), .segValid(segValid),
    .busy(busy), .done(done), .error(error)
  );

  sg_walk_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
    .PAGE_BYTES(PAGE_BYTES), .MEM_BYTES(MEM_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tableBase(tableBase), .maxIndex(maxIndex), .linOffset(linOffset),
    .byteLen(byteLen), .dirWrite(dirWrite), .descRdData(descRdData),
    .stat(stat), .descRdAddr(descRdAddr), .segAddr(segAddr),
    .segLen(segLen), .segWrite(segWrite)
  );

  assert_seg_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (segLen != '0) && (segLen <= LEN_W'(PAGE_BYTES)));

  assert_no_seg_with_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> !error);

endmodule

// File: tb/sg_page_walker_tb.sv
module sg_page_walker_tb;

  localparam int PG = 4096;
  localparam longint MEM = 1048576;
  localparam logic [31:0] TBASE = 32'h0008_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tableBase = TBASE;
  logic [15:0] maxIndex = 16'hFFFF;
  logic [31:0] linOffset = '0;
  logic [31:0] byteLen = '0;
  logic        dirWrite = 1'b0;
  logic        busy, done, error;
  logic        descRdValid;
  logic        descRdReady = 1'b0;
  logic [31:0] descRdAddr;
  logic [31:0] descRdData = '0;
  logic        segValid;
  logic        segReady = 1'b0;
  logic [31:0] segAddr;
  logic [31:0] segLen;
  logic        segWrite;
  logic        segDone = 1'b0;

  int checks = 0;
  int fails = 0;

  logic [31:0] dLog [0:15];
  logic [31:0] aLog [0:15];
  logic [31:0] lLog [0:15];
  logic        wLog [0:15];
  int dCnt = 0;
  int sCnt = 0;
  int overlap = 0;
  logic segBusy = 1'b0;

  always #2.5 clk = ~clk;

  sg_page_walker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .tableBase(tableBase),
    .maxIndex(maxIndex), .linOffset(linOffset), .byteLen(byteLen),
    .dirWrite(dirWrite), .busy(busy), .done(done), .error(error),
    .descRdValid(descRdValid), .descRdReady(descRdReady),
    .descRdAddr(descRdAddr), .descRdData(descRdData),
    .segValid(segValid), .segReady(segReady), .segAddr(segAddr),
    .segLen(segLen), .segWrite(segWrite), .segDone(segDone)
  );

  function automatic logic [31:0] descFor(input logic [31:0] idx);
    if (idx == 7) return 32'(MEM - 100);
    return 32'h0001_0000 + idx * 32'h3000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // descriptor memory responder
  initial begin
    forever begin
      @(negedge clk);
      descRdReady = 1'b0;
      if (descRdValid) begin
        if (segBusy) overlap++;
        repeat (2) @(negedge clk);
        descRdReady = 1'b1;
        descRdData = descFor((descRdAddr - TBASE) >> 3);
        if (dCnt < 16) dLog[dCnt] = descRdAddr;
        dCnt++;
        @(negedge clk);
        descRdReady = 1'b0;
      end
    end
  end

  // segment responder
  initial begin
    forever begin
      @(negedge clk);
      segReady = 1'b0;
      if (segValid) begin
        repeat (1) @(negedge clk);
        segReady = 1'b1;
        if (sCnt < 16) begin
          aLog[sCnt] = segAddr; lLog[sCnt] = segLen; wLog[sCnt] = segWrite;
        end
        sCnt++;
        @(negedge clk);
        segReady = 1'b0;
        segBusy = 1'b1;
        repeat (3) @(negedge clk);
        segDone = 1'b1;
        segBusy = 1'b0;
        @(negedge clk);
        segDone = 1'b0;
      end
    end
  end

  // one walk compared against an independent model
  task automatic runWalk(input string tag, input logic [31:0] off, input logic [31:0] len,
                         input logic dir, input logic [15:0] maxIdx, input logic poke);
    logic [31:0] eD [0:15];
    logic [31:0] eA [0:15];
    logic [31:0] eL [0:15];
    int nd, ns, waitCnt;
    logic eErr, gotErr, gotDone;
    longint idx, inp, rem, sl, phys;
    nd = 0; ns = 0; eErr = 1'b0;
    idx = off / PG; inp = off % PG; rem = len;
    while (rem > 0) begin
      if (idx > maxIdx) begin eErr = 1'b1; break; end
      eD[nd] = TBASE + 32'(idx) * 8; nd++;
      phys = longint'(descFor(32'(idx))) + inp;
      sl = (PG - inp < rem) ? PG - inp : rem;
      if (phys + sl > MEM) begin eErr = 1'b1; break; end
      eA[ns] = 32'(phys); eL[ns] = 32'(sl); ns++;
      rem -= sl; idx++; inp = 0;
    end
    @(negedge clk);
    dCnt = 0; sCnt = 0; overlap = 0;
    linOffset = off; byteLen = len; dirWrite = dir; maxIndex = maxIdx;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotDone = 1'b0; gotErr = 1'b0; waitCnt = 0;
    fork
      begin
        while (!done && waitCnt < 2000) begin @(negedge clk); waitCnt++; end
        gotDone = done; gotErr = error;
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, 32'(done), 32'd0);
        chk({tag, " R9 error held"}, 32'(error), 32'(eErr));
      end
      begin
        if (poke) begin
          @(posedge segDone);
          start = 1'b1; linOffset = 32'h0004_0000; byteLen = 32'd5;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    chk({tag, " R9 done seen"}, 32'(gotDone), 32'd1);
    chk({tag, " R7/R8 error"}, 32'(gotErr), 32'(eErr));
    chk({tag, " R2 descriptor count"}, 32'(dCnt), 32'(nd));
    chk({tag, " R4 segment count"}, 32'(sCnt), 32'(ns));
    chk({tag, " R6 no fetch while outstanding"}, 32'(overlap), 32'd0);
    for (int i = 0; i < nd && i < dCnt && i < 16; i++)
      chk({tag, " R2 descriptor address"}, dLog[i], eD[i]);
    for (int i = 0; i < ns && i < sCnt && i < 16; i++) begin
      chk({tag, (i == 0) ? " R3 first address" : " R4 address"}, aLog[i], eA[i]);
      chk({tag, (i == 0) ? " R3 first length" : " R4 length"}, lLog[i], eL[i]);
      chk({tag, " R5 direction"}, 32'(wLog[i]), 32'(dir));
    end
  endtask

  task automatic testReset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 error", 32'(error), 0);
    chk("R1 descRdValid", 32'(descRdValid), 0);
    chk("R1 segValid", 32'(segValid), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runWalk("aligned R2", 32'h2000, 32'h100, 1'b1, 16'hFFFF, 1'b0);
    runWalk("span R3 R4", 32'h1F00, 32'h2200, 1'b0, 16'hFFFF, 1'b0);
    runWalk("page tail R3", 32'h0FF0, 32'h10, 1'b1, 16'hFFFF, 1'b0);
    runWalk("limit hit R7", 32'h3F00, 32'h200, 1'b1, 16'd3, 1'b0);
    runWalk("start over R7", 32'h5000, 32'h10, 1'b0, 16'd3, 1'b0);
    runWalk("mem edge R8", 32'h7000, 32'd100, 1'b1, 16'hFFFF, 1'b0);
    runWalk("mem over R8", 32'h7000, 32'd101, 1'b1, 16'hFFFF, 1'b0);
    runWalk("zero R10", 32'h1234, 32'd0, 1'b1, 16'hFFFF, 1'b0);
    runWalk("busy start R11", 32'h0800, 32'h1900, 1'b0, 16'hFFFF, 1'b1);
    repeat (4) @(negedge clk);
    chk("R11 idle after walk", 32'(busy), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule